// File: doc/BRIEF.md
# Time-Triggered Sync Pulse Generator

This block drives a single timing output from a free-running nanosecond time-of-day value that is supplied from outside. Software describes the pulse shape with three packed 16-bit words: a 30-bit period and a 9-bit high time, both counted in 8 ns units. It also supplies a 48-bit start time in nanoseconds. The start time is written into a staging copy. That copy becomes active only on a frame-sync strobe, and only when a load request is pending.

Two enable bits in a control word select the behaviour. A 0-to-1 change of the single-pulse bit gives one pulse at the start time. A 0-to-1 change of the repeat bit gives a pulse train that begins at the start time and repeats every period. Writing a control word with both enable bits low stops the output at once. A shape with a zero or over-long high time is refused when arming is attempted.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset, sync_out is low and stays low until arming takes place, even though the time keeps advancing.
- R2: The control word is at address 6, with bit 0 = single pulse, bit 1 = repeat and bit 2 = load request. When bit 0 rises from 0 to 1, sync_out goes high on the first clock edge that samples tod_ns >= the active start time. It then stays high while tod_ns < rise time + 8*width, and afterwards it does not rise again.
- R3: Writing the control word with bit 0 already 1 and bit 1 unchanged does not arm again. No new pulse follows.
- R4: When bit 1 rises from 0 to 1, pulses start at the active start time and repeat every 8*period ns.
- R5: The shape is packed as follows. Address 0 holds period[15:0]. Address 1 holds period[29:16] in bits 13:0 and width[1:0] in bits 15:14. Address 2 holds width[8:2] in bits 6:0.
- R6: Addresses 3, 4 and 5 stage start-time bits 15:0, 31:16 and 47:32. A frame_sync pulse copies the staged value to the active start time only while a load request is pending. That request then clears, so a later frame_sync without a new request changes nothing.
- R7: Bits 3:0 of the start time are always taken as zero.
- R8: Arming is ignored when width is 0 or width > period. No pulse appears in that case.
- R9: A control write with bits 1:0 both 0 drives sync_out low after the clock edge that samples it, and it cancels any pending pulse.
- R10: A start time that is already in the past fires on the first compare after arming and gives a full-width pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0-6) |
| wr_data | input | 16 | Register write data |
| frame_sync | input | 1 | Applies the staged start time when a load is pending |
| tod_ns | input | 48 | Current time of day in nanoseconds |
| sync_out | output | 1 | Generated timing pulse |

## Verification
Each register write or frame-sync strobe takes effect at the clock edge that samples it. An arming write therefore allows a compare no earlier than the following edge. The output rises at the edge that sees tod_ns reach the start time, and it falls at the edge that sees rise time plus the high time. An off command takes effect at the edge that samples it. The bench advances the time by 8 ns on each falling edge and samples sync_out together with tod_ns one nanosecond after each rising edge. A rise is therefore recorded against exactly the time value that caused it, and a pulse of N units shows as N high samples.

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen #(
  parameter int UNIT_SHIFT = 3,
  parameter int ALIGN_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        frame_sync,
  input  logic [47:0] tod_ns,
  output logic        sync_out
);
  localparam int TIME_W = 48;

  logic [15:0]           per_lo;
  logic [13:0]           per_hi;
  logic [1:0]            wid_lo;
  logic [6:0]            wid_hi;
  logic [15:ALIGN_BITS]  stg0;
  logic [15:0]           stg1, stg2;
  logic [TIME_W-1:0]     tgt_act, next_rise, fall_at;
  logic                  en_os, en_per, load_pend, armed;

  wire [29:0]       period   = {per_hi, per_lo};
  wire [8:0]        width    = {wid_hi, wid_lo};
  wire [TIME_W-1:0] staged   = {stg2, stg1, stg0, {ALIGN_BITS{1'b0}}};
  wire [TIME_W-1:0] per_ns   = TIME_W'(period) << UNIT_SHIFT;
  wire [TIME_W-1:0] wid_ns   = TIME_W'(width) << UNIT_SHIFT;
  wire              ctrl_wr  = wr_en && wr_addr == 3'd6;
  wire              go_off   = ctrl_wr && wr_data[1:0] == 2'b00;
  wire              start    = ctrl_wr && ((wr_data[0] && !en_os) || (wr_data[1] && !en_per));
  wire              shape_ok = width != 9'd0 && 30'(width) <= period;
  wire              load_now = frame_sync && load_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_lo <= '0; per_hi <= '0; wid_lo <= '0; wid_hi <= '0;
      stg0 <= '0; stg1 <= '0; stg2 <= '0;
      tgt_act <= '0; next_rise <= '0; fall_at <= '0;
      en_os <= 1'b0; en_per <= 1'b0; load_pend <= 1'b0; armed <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      if (load_now) begin
        tgt_act   <= staged;
        load_pend <= 1'b0;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: per_lo <= wr_data;
          3'd1: begin per_hi <= wr_data[13:0]; wid_lo <= wr_data[15:14]; end
          3'd2: wid_hi <= wr_data[6:0];
          3'd3: stg0 <= wr_data[15:ALIGN_BITS];
          3'd4: stg1 <= wr_data;
          3'd5: stg2 <= wr_data;
          3'd6: begin
            en_os  <= wr_data[0];
            en_per <= wr_data[1];
            if (wr_data[2]) load_pend <= 1'b1;
          end
          default: ;
        endcase
      end
      if (go_off) begin
        armed    <= 1'b0;
        sync_out <= 1'b0;
      end else if (start && shape_ok) begin
        armed     <= 1'b1;
        next_rise <= load_now ? staged : tgt_act;
      end else begin
        if (sync_out && tod_ns >= fall_at) sync_out <= 1'b0;
        if (armed && tod_ns >= next_rise) begin
          sync_out  <= 1'b1;
          fall_at   <= tod_ns + wid_ns;
          next_rise <= next_rise + per_ns;
          armed     <= en_per;
        end
      end
    end
  end

  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd6 && wr_data[1:0] == 2'b00) |=> !sync_out);

  p_rise_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> $past(armed) && $past(tod_ns) >= $past(next_rise));

  p_single_shot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_out) && !$past(en_per)) |-> !armed);

  p_load_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !(ctrl_wr && wr_data[2])) |=> !load_pend);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !sync_out && !armed);
endmodule

// File: tb/test_sync_pulse_gen.sv
`timescale 1ns/1ps
module test_sync_pulse_gen;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, frame_sync = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [47:0] tod_ns = '0;
  wire         sync_out;

  int checks = 0, fails = 0, highs = 0, rises = 0;
  logic [47:0] first_rise, second_rise;

  sync_pulse_gen i_sync_pulse_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_sync(frame_sync), .tod_ns(tod_ns),
    .sync_out(sync_out));

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tod_ns = tod_ns + 48'd8;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic fsync();
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
  endtask

  task automatic shape(input logic [8:0] w, input logic [29:0] p);
    wr(3'd0, p[15:0]);
    wr(3'd1, {w[1:0], p[29:16]});
    wr(3'd2, {9'd0, w[8:2]});
  endtask

  task automatic stage(input logic [47:0] t);
    wr(3'd3, t[15:0]); wr(3'd4, t[31:16]); wr(3'd5, t[47:32]);
  endtask

  task automatic load_target(input logic [47:0] t);
    stage(t);
    wr(3'd6, 16'h0004);
    fsync();
  endtask

  function automatic logic [47:0] ahead(input int d);
    return ((tod_ns + 48'(d)) >> 4) << 4;
  endfunction

  task automatic watch(input int n);
    bit prev = sync_out;
    rises = 0; highs = 0; first_rise = '0; second_rise = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (sync_out && !prev) begin
        if (rises == 0) first_rise = tod_ns;
        if (rises == 1) second_rise = tod_ns;
        rises++;
      end
      if (sync_out) highs++;
      prev = sync_out;
    end
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    chk(sync_out == 1'b0, "R1 low after reset", sync_out, 0);
    watch(40);
    chk(rises == 0, "R1 idle without arming", rises, 0);
  endtask

  task automatic t_oneshot();
    logic [47:0] t;
    shape(9'd5, 30'd100);
    t = ahead(800);
    load_target(t);
    wr(3'd6, 16'h0001);
    watch(200);
    chk(rises == 1, "R2 single rise", rises, 1);
    chk(first_rise == t, "R2 rise time", first_rise, t);
    chk(highs == 5, "R2 R5 width", highs, 5);
  endtask

  task automatic t_rearm();
    wr(3'd6, 16'h0001);
    watch(60);
    chk(rises == 0, "R3 no re-arm without 0-to-1", rises, 0);
    wr(3'd6, 16'h0000);
  endtask

  task automatic t_periodic_off();
    logic [47:0] t;
    shape(9'd6, 30'd20);
    t = ahead(400);
    load_target(t);
    wr(3'd6, 16'h0002);
    watch(120);
    chk(rises >= 3, "R4 repeats", rises, 3);
    chk(first_rise == t, "R4 first rise", first_rise, t);
    chk(second_rise == t + 48'd160, "R4 period spacing", second_rise, t + 48'd160);
    chk(highs == 6 * rises || highs == 6 * rises - (6 - highs % 6) % 6, "R4 R5 width per pulse", highs, 6 * rises);
    do begin @(posedge clk); #1; end while (!sync_out);
    wr(3'd6, 16'h0000);
    #1;
    chk(sync_out == 1'b0, "R9 off within one clock", sync_out, 0);
    watch(100);
    chk(rises == 0, "R9 no pulses after off", rises, 0);
  endtask

  task automatic t_illegal();
    logic [47:0] t;
    shape(9'd10, 30'd4);
    t = ahead(300);
    load_target(t);
    wr(3'd6, 16'h0001);
    watch(80);
    chk(rises == 0, "R8 width above period", rises, 0);
    wr(3'd6, 16'h0000);
    shape(9'd0, 30'd100);
    t = ahead(300);
    load_target(t);
    wr(3'd6, 16'h0001);
    watch(80);
    chk(rises == 0, "R8 zero width", rises, 0);
    wr(3'd6, 16'h0000);
    shape(9'd10, 30'h0001_0004);
    t = ahead(300);
    load_target(t);
    wr(3'd6, 16'h0001);
    watch(80);
    chk(rises == 1, "R5 period high field makes shape legal", rises, 1);
    chk(highs == 10, "R5 split width field", highs, 10);
    wr(3'd6, 16'h0000);
  endtask

  task automatic t_noload();
    logic [47:0] ta, tb;
    shape(9'd4, 30'd100);
    ta = ahead(800);
    load_target(ta);
    tb = ahead(400);
    stage(tb);
    fsync();
    wr(3'd6, 16'h0001);
    watch(150);
    chk(first_rise == ta, "R6 frame sync without load ignored", first_rise, ta);
    chk(rises == 1, "R6 one pulse", rises, 1);
    wr(3'd6, 16'h0000);
  endtask

  task automatic t_align();
    logic [47:0] t;
    shape(9'd4, 30'd100);
    t = ahead(400);
    load_target(t + 48'd15);
    wr(3'd6, 16'h0001);
    watch(100);
    chk(first_rise == t, "R7 low bits dropped", first_rise, t);
    wr(3'd6, 16'h0000);
  endtask

  task automatic t_passed();
    shape(9'd7, 30'd100);
    load_target(48'd16);
    wr(3'd6, 16'h0001);
    watch(20);
    chk(rises == 1, "R10 past target fires", rises, 1);
    chk(highs == 7, "R10 full width", highs, 7);
    wr(3'd6, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_oneshot();
    t_rearm();
    t_periodic_off();
    t_illegal();
    t_noload();
    t_align();
    t_passed();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule